// File: doc/BRIEF.md
# Timer Event Status Flag Register

This block holds the sticky event flags of one timer channel in an 8-bit register. Pulses from the channel counter and from the compare/capture logic set the flags. A flag stays set until software clears it. Two channels use two instances.

A flag clears only through a two-step handshake. The CPU must first read the register while the flag shows 1. It then writes 0 to that bit position. A write that comes without the earlier read leaves the flag alone, and software can never set a flag. The two upper bits carry no state and always read as one.

Every flag that is set and has its bit on in a separate enable vector requests an interrupt. The request leaves the block through one registered output.

Top module: `tes_status_reg`

## Requirements
- R1: After the active-low asynchronous reset, rdata_o reads 8'hC0 and irq_o is 0.
- R2: Bits 7 and 6 of rdata_o always read 1. Writes to those bit positions have no effect.
- R3: A one-cycle pulse on unf_evt_i sets bit 5, and a pulse on ovf_evt_i sets bit 4. In both cases the flag is visible on rdata_o after the clock edge that samples the pulse.
- R4: Bit 3 sets on d_match_i only while d_capt_mode_i is 0 (compare mode). It sets on d_capt_i only while d_capt_mode_i is 1 (capture mode). The pulse that does not match the current mode is ignored.
- R5: A pulse on low_evt_i[k] sets bit k, for k = 0, 1 and 2.
- R6: A write with bit k = 0 clears flag k only if an earlier read strobe (rd_i) returned bit k as 1 and no other write came in between. The other flags in the same write are cleared or kept by the same rule, each one on its own.
- R7: A write with bit k = 0 that has no such earlier read leaves flag k set. Writing 1 to bit k never changes flag k.
- R8: Every write consumes all read arms, whatever value it writes. A second write of 0 after a write of 1 does not clear a flag.
- R9: If a set pulse and a valid clear reach the same flag in the same cycle, the flag stays 1.
- R10: irq_o is registered. At each clock edge it takes the OR over k of (flag k AND irq_en_i[k]), using the values present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe. Arms every flag that currently reads 1 |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data. A 0 bit requests a clear of that flag |
| rdata_o | output | 8 | Register value: {2'b11, flags[5:0]} |
| irq_en_i | input | 6 | Interrupt enable for each flag, taken from the enable register |
| unf_evt_i | input | 1 | Counter underflow pulse |
| ovf_evt_i | input | 1 | Counter overflow pulse |
| d_match_i | input | 1 | Counter equals general register D |
| d_capt_i | input | 1 | Input capture has loaded general register D |
| d_capt_mode_i | input | 1 | General register D mode: 1 = capture, 0 = compare |
| low_evt_i | input | 3 | Compare/capture pulses for flags 2..0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions run on every cycle. They check that each event pulse shows up as its flag on the next cycle, that a flag rises only when an event came one cycle before, that a flag falls only after a write of 0 to its bit, and that irq_o follows the enabled flags with exactly one cycle of delay. The read-then-write handshake depends on history over several cycles, so only the bench scenarios can show it. Those scenarios cover: a write with no read before it, a write of 1 that uses up the arm, a read taken while the flag was still 0, partial clears, and a set and a clear in the same cycle. A behavioural model, compared on every clock, covers mixed traffic.

// File: rtl/tes_pkg.sv
package tes_pkg;
  localparam int unsigned RSV_BITS = 2;
  typedef enum logic {
    D_MODE_CMP = 1'b0,
    D_MODE_CAP = 1'b1
  } d_mode_e;
endpackage

// File: rtl/tes_evt_merge.sv
module tes_evt_merge #(
  parameter int unsigned NUM_FLAGS = 6,
  localparam int unsigned LOW_N = NUM_FLAGS - 3
) (
  input  logic                 unf_i,
  input  logic                 ovf_i,
  input  logic                 d_match_i,
  input  logic                 d_capt_i,
  input  logic                 d_mode_i,
  input  logic [LOW_N-1:0]     low_i,
  output logic [NUM_FLAGS-1:0] set_o
);
  import tes_pkg::*;

  localparam int unsigned UNF_IDX = NUM_FLAGS - 1;
  localparam int unsigned OVF_IDX = NUM_FLAGS - 2;
  localparam int unsigned D_IDX   = NUM_FLAGS - 3;

  d_mode_e d_mode;
  logic    d_evt;

  assign d_mode = d_mode_e'(d_mode_i);

  // the mode decides which of the two D sources is live
  always_comb begin
    unique case (d_mode)
      D_MODE_CAP: d_evt = d_capt_i;
      default:    d_evt = d_match_i;
    endcase
  end

  always_comb begin
    set_o          = '0;
    set_o[UNF_IDX] = unf_i;
    set_o[OVF_IDX] = ovf_i;
    set_o[D_IDX]   = d_evt;
    set_o[LOW_N-1:0] = low_i;
  end
endmodule

// File: rtl/tes_flag_cell.sv
module tes_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q;
  logic clr;

  // clear needs an arm left by an earlier read
  assign clr = wr_i & arm_q & ~wbit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= set_i | (flag_q & ~clr);
      // any write consumes the arm; a read arms only a flag showing 1
      arm_q  <= (rd_i & flag_q) | (arm_q & ~wr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tes_irq_reg.sv
module tes_irq_reg #(
  parameter int unsigned NUM_FLAGS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [NUM_FLAGS-1:0] en_i,
  output logic                 irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flags_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tes_status_reg.sv
module tes_status_reg #(
  parameter int unsigned REG_W = 8,
  localparam int unsigned NUM_FLAGS = REG_W - tes_pkg::RSV_BITS,
  localparam int unsigned LOW_N = NUM_FLAGS - 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  input  logic [NUM_FLAGS-1:0] irq_en_i,
  input  logic                 unf_evt_i,
  input  logic                 ovf_evt_i,
  input  logic                 d_match_i,
  input  logic                 d_capt_i,
  input  logic                 d_capt_mode_i,
  input  logic [LOW_N-1:0]     low_evt_i,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;
  logic                 unused_rsv_wr;

  assign unused_rsv_wr = ^wdata_i[REG_W-1:NUM_FLAGS];

  tes_evt_merge #(.NUM_FLAGS(NUM_FLAGS)) i_evt_merge (
    .unf_i    (unf_evt_i),
    .ovf_i    (ovf_evt_i),
    .d_match_i(d_match_i),
    .d_capt_i (d_capt_i),
    .d_mode_i (d_capt_mode_i),
    .low_i    (low_evt_i),
    .set_o    (set_vec)
  );

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    tes_flag_cell i_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_vec[k]),
      .rd_i  (rd_i),
      .wr_i  (wr_i),
      .wbit_i(wdata_i[k]),
      .flag_o(flags[k])
    );
  end

  tes_irq_reg #(.NUM_FLAGS(NUM_FLAGS)) i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flags_i(flags),
    .en_i   (irq_en_i),
    .irq_o  (irq_o)
  );

  assign rdata_o = {{tes_pkg::RSV_BITS{1'b1}}, flags};
endmodule

// File: rtl/tes_status_chk.sv
module tes_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       wd_ovf_i,
  input logic [7:0] rdata_o,
  input logic [5:0] irq_en_i,
  input logic       unf_evt_i,
  input logic       ovf_evt_i,
  input logic       d_match_i,
  input logic       d_capt_mode_i,
  input logic       low0_evt_i,
  input logic       irq_o
);
  // R3
  unf_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_evt_i |=> rdata_o[5]);
  // R3
  ovf_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> rdata_o[4]);
  // R4
  d_cmp_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_match_i && !d_capt_mode_i) |=> rdata_o[3]);
  // R5
  low0_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low0_evt_i |=> rdata_o[0]);
  // R7
  ovf_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_o[4]) |-> $past(ovf_evt_i));
  // R6
  ovf_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdata_o[4]) |-> $past(wr_i && !wd_ovf_i));
  // R10
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(rdata_o[5:0] & irq_en_i))));
endmodule

bind tes_status_reg tes_status_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_i         (wr_i),
  .wd_ovf_i     (wdata_i[4]),
  .rdata_o      (rdata_o),
  .irq_en_i     (irq_en_i),
  .unf_evt_i    (unf_evt_i),
  .ovf_evt_i    (ovf_evt_i),
  .d_match_i    (d_match_i),
  .d_capt_mode_i(d_capt_mode_i),
  .low0_evt_i   (low_evt_i[0]),
  .irq_o        (irq_o)
);

// File: tb/test_tes_status_reg.sv
module test_tes_status_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] en = '0;
  logic       unf = 0, ovf = 0, dm = 0, dc = 0, dmode = 0;
  logic [2:0] low = '0;
  logic       irq;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  int m_flags = 0, m_arm = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tes_status_reg i_tes_status_reg (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_en_i(en), .unf_evt_i(unf), .ovf_evt_i(ovf),
    .d_match_i(dm), .d_capt_i(dc), .d_capt_mode_i(dmode), .low_evt_i(low),
    .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin : model
    int s, c, nf, na;
    if (!rst_n) begin
      m_flags = 0; m_arm = 0; m_irq = 0;
    end else begin
      s = 0;
      if (unf) s = s + 32;
      if (ovf) s = s + 16;
      if ((dmode && dc) || (!dmode && dm)) s = s + 8;
      s = s + int'(low);
      c = wr ? (m_arm & ~int'(wdata) & 63) : 0;
      nf = (m_flags & ~c) | s;
      na = (wr ? 0 : m_arm) | (rd ? m_flags : 0);
      m_irq = ((m_flags & int'(en)) != 0) ? 1 : 0;
      m_flags = nf;
      m_arm = na;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 model rdata", int'(rdata), 192 + m_flags);
      check("R10 model irq", int'(irq), m_irq);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic do_rd(); rd = 1; tick(); rd = 0; endtask
  task automatic do_wr(input logic [7:0] v); wr = 1; wdata = v; tick(); wr = 0; wdata = '0; endtask
  task automatic clr_all(); do_rd(); do_wr(8'h00); endtask

  initial begin
    repeat (3) tick();
    check("R1 reset rdata", int'(rdata), 'hC0);
    check("R1 reset irq", int'(irq), 0);
    rst_n = 1; tick();

    unf = 1; tick(); unf = 0;
    check("R3 underflow", int'(rdata), 'hE0);
    ovf = 1; tick(); ovf = 0;
    check("R3 overflow", int'(rdata), 'hF0);

    do_wr(8'h00);
    check("R7 write0 no read", int'(rdata), 'hF0);
    do_wr(8'hFF);
    check("R7 write1 no set", int'(rdata), 'hF0);
    check("R2 reserved after FF", int'(rdata[7:6]), 3);

    clr_all();
    check("R6 read then clear", int'(rdata), 'hC0);
    check("R2 reserved after 00", int'(rdata[7:6]), 3);

    dmode = 1; dm = 1; tick(); dm = 0;
    check("R4 match ignored in capture mode", int'(rdata), 'hC0);
    dmode = 0; dc = 1; tick(); dc = 0;
    check("R4 capture ignored in compare mode", int'(rdata), 'hC0);
    dm = 1; tick(); dm = 0;
    check("R4 compare match", int'(rdata), 'hC8);
    clr_all();
    dmode = 1; dc = 1; tick(); dc = 0; dmode = 0;
    check("R4 input capture", int'(rdata), 'hC8);

    low = 3'b101; tick(); low = '0;
    check("R5 low 101", int'(rdata), 'hCD);
    low = 3'b010; tick(); low = '0;
    check("R5 low 010", int'(rdata), 'hCF);

    do_rd(); do_wr(8'hFF); do_wr(8'h00);
    check("R8 write consumes arm", int'(rdata), 'hCF);

    do_rd(); do_wr(8'hF7);
    check("R6 partial clear", int'(rdata), 'hC7);

    clr_all();
    check("R6 clear all", int'(rdata), 'hC0);
    do_rd();
    ovf = 1; tick(); ovf = 0;
    do_wr(8'h00);
    check("R6 read while zero does not arm", int'(rdata), 'hD0);

    do_rd();
    wr = 1; wdata = 8'h00; ovf = 1; tick(); wr = 0; ovf = 0;
    check("R9 set beats clear", int'(rdata), 'hD0);
    clr_all();

    en = 6'b100000;
    ovf = 1; tick(); ovf = 0;
    tick();
    check("R10 masked flag no irq", int'(irq), 0);
    en = 6'b010000;
    tick();
    check("R10 irq one cycle late", int'(irq), 1);
    en = '0; tick();
    check("R10 irq drops with enable", int'(irq), 0);
    en = 6'b010000; tick();
    clr_all();
    check("R10 irq after clear edge", int'(irq), 1);
    tick();
    check("R10 irq gone", int'(irq), 0);

    // mixed traffic against model
    for (int i = 0; i < 400; i++) begin
      unf = (i % 7) == 0; ovf = (i % 11) == 3; dm = (i % 5) == 1;
      dc = (i % 9) == 2; dmode = (i % 13) < 6; low = 3'(i * 3);
      rd = (i % 4) == 0; wr = (i % 6) == 1; wdata = 8'(i * 37);
      en = 6'(i / 3);
      tick();
    end
    {unf, ovf, dm, dc, rd, wr} = '0; low = '0; wdata = '0;
    repeat (2) tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule